// File: doc/BRIEF.md
# Memory Read-Modify-Write Combo Sequencer

This block runs one fused memory-and-accumulator operation against a single-port synchronous byte memory. The surrounding core gives it an effective address that is already resolved, a three-bit operation group, an addressing-mode tag, the accumulator value and the incoming carry and overflow flags. The sequencer first waits out the operand-fetch cycles that the addressing mode implies. It then reads the addressed byte and transforms it with a shift, a rotate, an increment or a decrement. It writes the untouched byte back, writes the transformed byte, and finally merges the transformed byte into the accumulator.

The accumulator step always depends on the memory step. Its operand is the transformed byte. For the rotate-then-add group, the carry that goes into the add is the one the rotate shifted out. The caller sees a one-cycle `done` pulse together with the new accumulator and the four flags N, Z, C and V. These stay unchanged until the next completed operation. Decimal arithmetic and address calculation are left to the caller.

Top module: `rmw_combo_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `mem_re` and `mem_we` are 0, and `a_out` and all four flag outputs are 0.
- R2: Let edge k be the rising edge that accepts a start. `done` is high only in the clock period after edge k+N, where N is 5 for mode 0 (zero page), 6 for mode 1 (absolute) and 7 for modes 2 and 3 (indexed absolute). `busy` is high for the N periods before that.
- R3: The memory port does one read (`mem_re` high for one period after edge k+N-4). In the next period it writes the byte that was read back to the same address. In the period after that it writes the transformed byte to the same address. No other memory access occurs.
- R4: Group 0 shifts memory left with a 0 shifted in and the old bit 7 going to C. It then sets A = A OR new byte. N and Z follow the new A, and V keeps `v_in`.
- R5: Group 1 rotates memory left through `c_in`, with the old bit 7 going to C. It then sets A = A AND new byte. N and Z follow A, and V keeps `v_in`.
- R6: Group 2 shifts memory right with a 0 shifted in and the old bit 0 going to C. It then sets A = A XOR new byte. N and Z follow A, and V keeps `v_in`.
- R7: Group 3 rotates memory right through `c_in`. It then sets A = A + new byte + (old bit 0). C is the carry out of bit 7. V is set when both addends share a sign that differs from the sign of the result.
- R8: Group 6 decrements memory and compares A against the new byte. A is unchanged. C = (A >= new byte) unsigned, N and Z come from A minus the new byte, and V keeps `v_in`.
- R9: Group 7 increments memory and then sets A = A - new byte - (1 - `c_in`). C is 1 when no borrow occurs. V is set when A and the new byte differ in sign and the result's sign differs from A's.
- R10: A start while `busy` is high has no effect on timing, bus traffic or results. A start with group 4 or 5 is not accepted: `busy` stays 0 and no memory access follows.
- R11: A start presented in the period in which `done` is high is accepted, so two operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled when idle |
| op | input | 3 | Operation group (0,1,2,3,6,7 valid) |
| mode | input | 2 | Addressing mode: 0 zero page, 1 absolute, 2/3 indexed |
| ea | input | AW | Resolved effective address |
| a_in | input | DW | Accumulator value at start |
| c_in | input | 1 | Carry flag at start |
| v_in | input | 1 | Overflow flag at start |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read enable; data appears the next period |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| a_out | output | DW | Resulting accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-period completion pulse |

## Verification
Two events can fall in the same period. The first is the completion pulse of one operation together with the acceptance of the next start. The second is a stray start arriving during the final flag-update period, when the sequencer is about to go idle. The bench provokes the first by issuing a new start in the very period `done` is seen. It provokes the second by raising start in the last busy period with a different group and address. A reference model checks busy, done and every bus signal in each period against a timeline derived from the mode, and checks the results at the done period. Any early acceptance or lost start therefore shows up as a shifted bus pattern or a wrong result.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RD, S_DW, S_MW, S_FIN
  } seq_state_t;

  localparam logic [2:0] OP_SHL_OR  = 3'd0;
  localparam logic [2:0] OP_ROL_AND = 3'd1;
  localparam logic [2:0] OP_SHR_XOR = 3'd2;
  localparam logic [2:0] OP_ROR_ADC = 3'd3;
  localparam logic [2:0] OP_DEC_CMP = 3'd6;
  localparam logic [2:0] OP_INC_SBC = 3'd7;

  function automatic logic op_supported(input logic [2:0] op);
    return (op != 3'd4) && (op != 3'd5);
  endfunction
endpackage

// File: rtl/rmw_modify.sv
`timescale 1ns/1ps
module rmw_modify
  import rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] din,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  always_comb begin
    dout = din;
    cout = cin;
    case (op)
      OP_SHL_OR:  begin dout = {din[DW-2:0], 1'b0}; cout = din[DW-1]; end
      OP_ROL_AND: begin dout = {din[DW-2:0], cin};  cout = din[DW-1]; end
      OP_SHR_XOR: begin dout = {1'b0, din[DW-1:1]}; cout = din[0];    end
      OP_ROR_ADC: begin dout = {cin, din[DW-1:1]};  cout = din[0];    end
      OP_DEC_CMP: dout = din - {{(DW-1){1'b0}}, 1'b1};
      OP_INC_SBC: dout = din + {{(DW-1){1'b0}}, 1'b1};
      default:    ;
    endcase
  end
endmodule

// File: rtl/rmw_alu.sv
`timescale 1ns/1ps
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          mc,
  input  logic          v_in,
  output logic [DW-1:0] res,
  output logic          n,
  output logic          z,
  output logic          c,
  output logic          v
);
  localparam int MSB = DW - 1;

  logic [DW:0]   add_sum, sub_sum, cmp_sum;
  logic [DW-1:0] flag_src;

  assign add_sum = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, mc};
  assign sub_sum = {1'b0, a} + {1'b0, ~m} + {{DW{1'b0}}, mc};
  assign cmp_sum = {1'b0, a} + {1'b0, ~m} + {{DW{1'b0}}, 1'b1};

  always_comb begin
    res = a;
    c   = mc;
    v   = v_in;
    case (op)
      OP_SHL_OR:  res = a | m;
      OP_ROL_AND: res = a & m;
      OP_SHR_XOR: res = a ^ m;
      OP_ROR_ADC: begin
        res = add_sum[DW-1:0];
        c   = add_sum[DW];
        v   = ~(a[MSB] ^ m[MSB]) & (a[MSB] ^ add_sum[MSB]);
      end
      OP_DEC_CMP: c = cmp_sum[DW];
      OP_INC_SBC: begin
        res = sub_sum[DW-1:0];
        c   = sub_sum[DW];
        v   = (a[MSB] ^ m[MSB]) & (a[MSB] ^ sub_sum[MSB]);
      end
      default: ;
    endcase
    flag_src = (op == OP_DEC_CMP) ? cmp_sum[DW-1:0] : res;
    n = flag_src[MSB];
    z = (flag_src == '0);
  end
endmodule

// File: rtl/rmw_seq.sv
`timescale 1ns/1ps
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int ZP_WAIT  = 1,
  parameter int ABS_WAIT = 2,
  parameter int IDX_WAIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] op,
  input  logic [1:0] mode,
  output seq_state_t state,
  output logic       accept,
  output logic       done
);
  localparam int CW = $clog2(IDX_WAIT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] wait_len;

  always_comb begin
    case (mode)
      2'd0:    wait_len = CW'(ZP_WAIT);
      2'd1:    wait_len = CW'(ABS_WAIT);
      default: wait_len = CW'(IDX_WAIT);
    endcase
  end

  assign accept = (state == S_IDLE) && start && op_supported(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state <= S_WAIT;
          cnt   <= wait_len;
        end
        S_WAIT: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= S_RD;
        end
        S_RD:  state <= S_DW;
        S_DW:  state <= S_MW;
        S_MW:  state <= S_FIN;
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_fin_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state) == S_FIN);
  p_busy_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && state != S_FIN) |=> state != S_IDLE);
endmodule

// File: rtl/rmw_combo_seq.sv
`timescale 1ns/1ps
module rmw_combo_seq
  import rmw_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] a_in,
  input  logic          c_in,
  input  logic          v_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] a_out,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          busy,
  output logic          done
);
  seq_state_t    state;
  logic          accept;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] a_q, mod_q, mod_d, alu_res;
  logic          c_q, v_q, mc_q, mc_d;
  logic          alu_n, alu_z, alu_c, alu_v;

  rmw_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .mode(mode),
    .state(state), .accept(accept), .done(done)
  );

  rmw_modify #(.DW(DW)) u_modify (
    .op(op_q), .din(mem_rdata), .cin(c_q), .dout(mod_d), .cout(mc_d)
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op(op_q), .a(a_q), .m(mod_q), .mc(mc_q), .v_in(v_q),
    .res(alu_res), .n(alu_n), .z(alu_z), .c(alu_c), .v(alu_v)
  );

  assign busy      = (state != S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_re    = (state == S_RD);
  assign mem_we    = (state == S_DW) || (state == S_MW);
  assign mem_wdata = (state == S_DW) ? mem_rdata : mod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      addr_q <= '0;
      a_q    <= '0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
      mod_q  <= '0;
      mc_q   <= 1'b0;
      a_out  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      if (accept) begin
        op_q   <= op;
        addr_q <= ea;
        a_q    <= a_in;
        c_q    <= c_in;
        v_q    <= v_in;
      end
      if (state == S_DW) begin
        mod_q <= mod_d;
        mc_q  <= mc_d;
      end
      if (state == S_FIN) begin
        a_out  <= alu_res;
        flag_n <= alu_n;
        flag_z <= alu_z;
        flag_c <= alu_c;
        flag_v <= alu_v;
      end
    end
  end

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_re));
  p_write_pair_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |=> mem_we);
  p_write_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |=> !mem_we);
  p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> $stable(mem_addr));
  p_cmp_keeps_a_r8: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DEC_CMP) |-> a_out == a_q);
endmodule

// File: tb/test_rmw_combo_seq.sv
`timescale 1ns/1ps
module test_rmw_combo_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  mode = '0;
  logic [15:0] ea = '0;
  logic [7:0]  a_in = '0;
  logic        c_in = 1'b0;
  logic        v_in = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  a_out;
  logic        flag_n, flag_z, flag_c, flag_v, busy, done;

  int errors = 0;
  int checks = 0;
  logic [7:0] ram [256];

  always #4 clk = ~clk;

  rmw_combo_seq i_rmw_combo_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .mode(mode), .ea(ea),
    .a_in(a_in), .c_in(c_in), .v_in(v_in), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .a_out(a_out), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Behavioural reference for one operation.
  task automatic model(input int g, input int m, input int a, input int c, input int v,
                       output int md, output int r, output int n, output int z,
                       output int co, output int vo);
    int s, fl;
    vo = v;
    case (g)
      0: begin md = (m * 2) % 256; co = m / 128; r = a | md; fl = r; end
      1: begin md = (m * 2 + c) % 256; co = m / 128; r = a & md; fl = r; end
      2: begin md = m / 2; co = m % 2; r = a ^ md; fl = r; end
      3: begin
        md = m / 2 + c * 128; s = a + md + (m % 2);
        r = s % 256; co = (s > 255); fl = r;
        vo = (((a ^ r) & (md ^ r) & 128) != 0);
      end
      6: begin
        md = (m + 255) % 256; s = a - md;
        co = (a >= md); r = a; fl = (s + 256) % 256;
      end
      default: begin
        md = (m + 1) % 256; s = a - md - (1 - c);
        r = (s + 512) % 256; co = (s >= 0); fl = r;
        vo = (((a ^ md) & (a ^ r) & 128) != 0);
      end
    endcase
    n = fl / 128;
    z = (fl == 0);
  endtask

  // Starts at a negedge; returns at the negedge of the done period.
  // spur >= 0 raises a stray start in that busy period (R10).
  task automatic run_op(input int g, input int md_sel, input int adr, input int m,
                        input int a, input int c, input int v, input int spur);
    int n_cyc, w, emod, er, en, ez, ec, ev;
    w = (md_sel == 0) ? 1 : (md_sel == 1) ? 2 : 3;
    n_cyc = w + 4;
    ram[adr] = m[7:0];
    model(g, m, a, c, v, emod, er, en, ez, ec, ev);
    op = g[2:0]; mode = md_sel[1:0]; ea = adr[15:0];
    a_in = a[7:0]; c_in = c[0]; v_in = v[0];
    start = 1'b1;
    for (int i = 0; i <= n_cyc; i++) begin
      @(negedge clk);
      start = (i == spur);
      if (i == spur) begin
        op = 3'd2; ea = 16'h00ee; a_in = 8'h5a; c_in = ~c[0];
      end
      chk(busy == (i < n_cyc), "R2 busy", busy, i < n_cyc);
      chk(done == (i == n_cyc), "R2 done", done, i == n_cyc);
      chk(mem_re == (i == w), "R3 read strobe", mem_re, i == w);
      chk(mem_we == (i == w + 1 || i == w + 2), "R3 write strobe", mem_we,
          i == w + 1 || i == w + 2);
      if (mem_re || mem_we) chk(mem_addr == adr[15:0], "R3 address", mem_addr, adr);
      if (i == w + 1) chk(mem_wdata == m[7:0], "R3 dummy write", mem_wdata, m);
      if (i == w + 2) chk(mem_wdata == emod[7:0], "R3 modified write", mem_wdata, emod);
    end
    start = 1'b0;
    chk(a_out == er[7:0], $sformatf("R%0d_a group %0d", g == 6 ? 8 : g == 7 ? 9 : g + 4, g), a_out, er);
    chk(flag_n == en[0] && flag_z == ez[0], "R4..R9 NZ flags", {flag_n, flag_z}, {en[0], ez[0]});
    chk(flag_c == ec[0], "R4..R9 carry", flag_c, ec);
    chk(flag_v == ev[0], "R4..R9 overflow", flag_v, ev);
    chk(ram[adr] == emod[7:0], "R3 memory image", ram[adr], emod);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 256; k++) ram[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state while held and after release
    chk(!busy && !done && !mem_re && !mem_we, "R1 strobes in reset", {busy, done, mem_re, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R1 strobes after reset", {busy, done, mem_re, mem_we}, 0);
    chk(a_out == 8'h00 && {flag_n, flag_z, flag_c, flag_v} == 4'b0, "R1 results",
        {a_out, flag_n, flag_z, flag_c, flag_v}, 0);

    // R4 group 0 in zero-page mode, R5 in absolute, R6 in indexed (Z case)
    run_op(0, 0, 8'h10, 8'h81, 8'h10, 0, 1, -1);
    run_op(1, 1, 8'h20, 8'h80, 8'hff, 1, 0, -1);
    run_op(2, 2, 8'h30, 8'h01, 8'h00, 0, 0, -1);
    run_op(2, 3, 8'h31, 8'hf0, 8'h0f, 1, 1, -1);
    // R7: signed overflow, then carry out with overflow
    run_op(3, 0, 8'h40, 8'ha0, 8'h50, 0, 0, -1);
    run_op(3, 1, 8'h41, 8'h01, 8'h80, 1, 0, -1);
    run_op(3, 2, 8'h42, 8'h10, 8'h01, 0, 1, -1);
    // R8: wrap to FF (borrow), equal (Z,C), V preserved
    run_op(6, 0, 8'h50, 8'h00, 8'h10, 1, 1, -1);
    run_op(6, 2, 8'h51, 8'h11, 8'h10, 0, 0, -1);
    // R9: increment wrap, carry in both ways, overflow
    run_op(7, 1, 8'h60, 8'hff, 8'h05, 1, 0, -1);
    run_op(7, 0, 8'h61, 8'hff, 8'h05, 0, 0, -1);
    run_op(7, 2, 8'h62, 8'h00, 8'h80, 1, 0, -1);
    // R10: stray starts mid-operation and in the final update period
    run_op(1, 1, 8'h70, 8'h3c, 8'hf0, 1, 0, 2);
    run_op(3, 0, 8'h71, 8'h55, 8'h22, 1, 0, 4);
    // R11: the call below starts in the done period of the one above
    run_op(0, 2, 8'h72, 8'h40, 8'h01, 0, 0, -1);
    run_op(6, 0, 8'h73, 8'h80, 8'h7f, 0, 1, -1);

    // R10: unsupported groups 4 and 5 are not accepted
    for (int g = 4; g <= 5; g++) begin
      op = g[2:0]; mode = 2'd0; ea = 16'h0080; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 7; i++) begin
        chk(!busy && !mem_re && !mem_we && !done, "R10 unsupported group",
            {busy, mem_re, mem_we, done}, 0);
        @(negedge clk);
      end
    end
    finish_run();
  end
endmodule